// File: doc/BRIEF.md
# SPD Bus Command Controller

This block is a single-command two-wire bus master for reading and writing bytes in a memory-module presence-detect EEPROM. Host logic sets up a command: a read/write choice, a 4-bit device type, a 3-bit device select, a byte offset and, for writes, a data byte. It then pulses a strobe. The block runs exactly one bus transaction on SCL/SDA and reports the outcome through four status flags and a read-data byte.

The bus pins are open-drain. Each output is an enable that pulls its line low, and the SDA line level is read back on a separate input. A runtime divider sets the bus bit rate. Each quarter of a bit lasts `clk_div_i + 1` clock cycles. A write transaction is START, address with W=0, offset, data, STOP. A read transaction is START, address with W=0, offset, repeated START, address with R=1, one byte read, a master NACK, STOP. The block checks the acknowledge bit after every byte it transmits.

Top module: `spd_cmd_ctrl`

## Requirements
- R1: A strobe on `cmd_we_i` while `busy_o` is low starts exactly one transaction, which has exactly one START for a write and two STARTs for a read. `busy_o` is high from the cycle after the strobe until the transaction has ended with its STOP.
- R2: The address byte sent on the bus is the device type in bits 7:4, the device select in bits 3:1 and the R/W bit in bit 0 (1 = read). The type is sent unchanged: 4'b1010 targets the EEPROM array and 4'b0110 targets its write-protect function.
- R3: A write command sends START, the address with W=0, the offset byte, the data byte and STOP, and the data byte lands at that offset in the target device.
- R4: A read command sends the offset through a dummy write, then a repeated START, the address with R=1, reads one byte and NACKs it. On success it loads `rd_data_o` with that byte and sets `rd_valid_o`.
- R5: `rd_valid_o` is cleared when the next read command is accepted. Write commands leave it unchanged.
- R6: `wr_done_o` is set when a write completes without error. It is cleared when the next write command is accepted. Read commands leave it unchanged.
- R7: A missing acknowledge on any address, offset or data byte ends the transaction with a STOP and sets `bus_err_o`. In that case `wr_done_o` and `rd_valid_o` stay clear and `rd_data_o` keeps its previous value.
- R8: `bus_err_o` is cleared when any command is accepted.
- R9: A strobe while `busy_o` is high is ignored: it starts no transaction and changes nothing on the bus.
- R10: After reset `busy_o`, `rd_valid_o`, `wr_done_o` and `bus_err_o` are 0 and `rd_data_o` is 8'h00.
- R11: During a transaction, every SCL high pulse that begins with a rising edge lasts 2*(`clk_div_i`+1) clock cycles.
- R12: While `busy_o` is low, both `scl_oe_o` and `sda_oe_o` are 0, so both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_div_i | input | DIV_W | Quarter-bit length minus one, in clock cycles |
| cmd_we_i | input | 1 | Command strobe |
| cmd_rd_i | input | 1 | 1 = read command, 0 = write command |
| cmd_dev_type_i | input | 4 | Device type, address bits 7:4 |
| cmd_dev_sel_i | input | 3 | Device select, address bits 3:1 |
| cmd_offset_i | input | 8 | Byte offset inside the device |
| cmd_wdata_i | input | 8 | Byte to write |
| busy_o | output | 1 | Command executing |
| rd_valid_o | output | 1 | `rd_data_o` holds the byte of the last read |
| wr_done_o | output | 1 | Last write completed |
| bus_err_o | output | 1 | Last transaction failed on a missing acknowledge |
| rd_data_o | output | 8 | Byte returned by the last successful read |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Level seen on the SDA line |

## Verification
Completion of a transaction and acceptance of the next command can meet at the busy boundary. In the cycle where the STOP finishes, `wr_done_o` is set; a strobe held through that cycle is dropped there and taken on the following edge, where it clears the flag again. The bench holds `cmd_we_i` high with a second write across the end of a first write. It expects `wr_done_o` high in exactly the one cycle where `busy_o` is low, then busy again with the flag clear. It then checks that exactly one further transaction ran and that it wrote its byte.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int BYTE_W  = 8;
  localparam int DTYPE_W = 4;
  localparam int SEL_W   = 3;

  typedef enum logic [1:0] {EOP_START, EOP_STOP, EOP_BYTE} eng_op_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_START, SQ_ADDR_W, SQ_OFFSET, SQ_WDATA,
    SQ_RSTART, SQ_ADDR_R, SQ_RDATA, SQ_STOP
  } seq_state_e;

  typedef struct packed {
    logic               rd;
    logic [DTYPE_W-1:0] dtype;
    logic [SEL_W-1:0]   sel;
    logic [BYTE_W-1:0]  offset;
    logic [BYTE_W-1:0]  wdata;
  } spd_cmd_t;
endpackage

// File: rtl/spd_clk_tick.sv
module spd_clk_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (cnt_q == div_i) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == div_i);
endmodule

// File: rtl/spd_bit_engine.sv
module spd_bit_engine
  import spd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              go_i,
  input  eng_op_e           op_i,
  input  logic [BYTE_W-1:0] tx_i,
  input  logic              sda_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] rx_o,
  output logic              ack_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  localparam int NBITS = BYTE_W + 1;          // data bits plus acknowledge slot
  localparam int BIT_W = $clog2(NBITS + 1);

  logic             active_q, tick;
  eng_op_e          op_q;
  logic [1:0]       ph_q;
  logic [BIT_W-1:0] bit_q;
  logic [NBITS-1:0] tx_sh_q, rx_sh_q;
  logic             scl_low_q, sda_low_q;

  spd_clk_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (active_q),
    .div_i (div_i),
    .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      op_q      <= EOP_START;
      ph_q      <= '0;
      bit_q     <= '0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i && !active_q) begin
        active_q <= 1'b1;
        op_q     <= op_i;
        ph_q     <= '0;
        bit_q    <= '0;
        tx_sh_q  <= {tx_i, 1'b1};              // ack slot released
      end else if (active_q && tick) begin
        ph_q <= ph_q + 1'b1;
        unique case (op_q)
          EOP_START: begin                      // also serves as repeated START
            unique case (ph_q)
              2'd0: sda_low_q <= 1'b0;
              2'd1: scl_low_q <= 1'b0;
              2'd2: sda_low_q <= 1'b1;
              default: begin
                scl_low_q <= 1'b1;
                active_q  <= 1'b0;
                done_o    <= 1'b1;
              end
            endcase
          end
          EOP_STOP: begin
            unique case (ph_q)
              2'd0: begin sda_low_q <= 1'b1; scl_low_q <= 1'b1; end
              2'd1: scl_low_q <= 1'b0;
              default: begin
                sda_low_q <= 1'b0;
                active_q  <= 1'b0;
                done_o    <= 1'b1;
              end
            endcase
          end
          default: begin
            unique case (ph_q)
              2'd0: sda_low_q <= ~tx_sh_q[NBITS-1];
              2'd1: scl_low_q <= 1'b0;
              2'd2: rx_sh_q   <= {rx_sh_q[NBITS-2:0], sda_i};
              default: begin
                scl_low_q <= 1'b1;
                tx_sh_q   <= {tx_sh_q[NBITS-2:0], 1'b1};
                bit_q     <= bit_q + 1'b1;
                if (bit_q == BIT_W'(NBITS - 1)) begin
                  active_q <= 1'b0;
                  done_o   <= 1'b1;
                end
              end
            endcase
          end
        endcase
      end
    end
  end

  assign rx_o     = rx_sh_q[NBITS-1:1];
  assign ack_o    = ~rx_sh_q[0];
  assign scl_oe_o = scl_low_q;
  assign sda_oe_o = sda_low_q;
endmodule

// File: rtl/spd_sequencer.sv
module spd_sequencer
  import spd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  spd_cmd_t          cmd_i,
  input  logic              eng_done_i,
  input  logic [BYTE_W-1:0] eng_rx_i,
  input  logic              eng_ack_i,
  output logic              eng_go_o,
  output eng_op_e           eng_op_o,
  output logic [BYTE_W-1:0] eng_tx_o,
  output logic              busy_o,
  output logic              rd_valid_o,
  output logic              wr_done_o,
  output logic              bus_err_o,
  output logic [BYTE_W-1:0] rd_data_o
);
  seq_state_e        state_q, nxt_state;
  spd_cmd_t          cmd_q;
  logic              err_q, nack;
  logic [BYTE_W-1:0] rd_byte_q;

  always_comb begin
    nxt_state = state_q;
    nack      = 1'b0;
    unique case (state_q)
      SQ_START:  nxt_state = SQ_ADDR_W;
      SQ_ADDR_W: begin nack = !eng_ack_i; nxt_state = nack ? SQ_STOP : SQ_OFFSET; end
      SQ_OFFSET: begin
        nack      = !eng_ack_i;
        nxt_state = nack ? SQ_STOP : (cmd_q.rd ? SQ_RSTART : SQ_WDATA);
      end
      SQ_WDATA:  begin nack = !eng_ack_i; nxt_state = SQ_STOP; end
      SQ_RSTART: nxt_state = SQ_ADDR_R;
      SQ_ADDR_R: begin nack = !eng_ack_i; nxt_state = nack ? SQ_STOP : SQ_RDATA; end
      SQ_RDATA:  nxt_state = SQ_STOP;
      SQ_STOP:   nxt_state = SQ_IDLE;
      default:   nxt_state = SQ_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      SQ_START, SQ_RSTART: eng_op_o = EOP_START;
      SQ_STOP:             eng_op_o = EOP_STOP;
      default:             eng_op_o = EOP_BYTE;
    endcase
    unique case (state_q)
      SQ_ADDR_W: eng_tx_o = {cmd_q.dtype, cmd_q.sel, 1'b0};
      SQ_ADDR_R: eng_tx_o = {cmd_q.dtype, cmd_q.sel, 1'b1};
      SQ_OFFSET: eng_tx_o = cmd_q.offset;
      SQ_WDATA:  eng_tx_o = cmd_q.wdata;
      default:   eng_tx_o = '1;               // read slot: SDA released
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SQ_IDLE;
      cmd_q      <= '0;
      err_q      <= 1'b0;
      rd_byte_q  <= '0;
      eng_go_o   <= 1'b0;
      rd_valid_o <= 1'b0;
      wr_done_o  <= 1'b0;
      bus_err_o  <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      eng_go_o <= 1'b0;
      if (state_q == SQ_IDLE) begin
        if (cmd_we_i) begin
          cmd_q     <= cmd_i;
          err_q     <= 1'b0;
          bus_err_o <= 1'b0;
          if (cmd_i.rd) rd_valid_o <= 1'b0;
          else          wr_done_o  <= 1'b0;
          state_q  <= SQ_START;
          eng_go_o <= 1'b1;
        end
      end else if (eng_done_i) begin
        state_q <= nxt_state;
        if (nack) err_q <= 1'b1;
        if (state_q == SQ_RDATA) rd_byte_q <= eng_rx_i;
        if (nxt_state != SQ_IDLE) eng_go_o <= 1'b1;
        if (state_q == SQ_STOP) begin
          if (err_q)         bus_err_o <= 1'b1;
          else if (cmd_q.rd) begin rd_valid_o <= 1'b1; rd_data_o <= rd_byte_q; end
          else               wr_done_o <= 1'b1;
        end
      end
    end
  end

  assign busy_o = (state_q != SQ_IDLE);
endmodule

// File: rtl/spd_cmd_ctrl.sv
module spd_cmd_ctrl
  import spd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIV_W-1:0]   clk_div_i,
  input  logic               cmd_we_i,
  input  logic               cmd_rd_i,
  input  logic [DTYPE_W-1:0] cmd_dev_type_i,
  input  logic [SEL_W-1:0]   cmd_dev_sel_i,
  input  logic [BYTE_W-1:0]  cmd_offset_i,
  input  logic [BYTE_W-1:0]  cmd_wdata_i,
  output logic               busy_o,
  output logic               rd_valid_o,
  output logic               wr_done_o,
  output logic               bus_err_o,
  output logic [BYTE_W-1:0]  rd_data_o,
  output logic               scl_oe_o,
  output logic               sda_oe_o,
  input  logic               sda_i
);
  spd_cmd_t          cmd;
  logic              eng_go, eng_done, eng_ack;
  eng_op_e           eng_op;
  logic [BYTE_W-1:0] eng_tx, eng_rx;

  assign cmd = '{rd: cmd_rd_i, dtype: cmd_dev_type_i, sel: cmd_dev_sel_i,
                 offset: cmd_offset_i, wdata: cmd_wdata_i};

  spd_sequencer u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_we_i  (cmd_we_i),
    .cmd_i     (cmd),
    .eng_done_i(eng_done),
    .eng_rx_i  (eng_rx),
    .eng_ack_i (eng_ack),
    .eng_go_o  (eng_go),
    .eng_op_o  (eng_op),
    .eng_tx_o  (eng_tx),
    .busy_o    (busy_o),
    .rd_valid_o(rd_valid_o),
    .wr_done_o (wr_done_o),
    .bus_err_o (bus_err_o),
    .rd_data_o (rd_data_o)
  );

  spd_bit_engine #(.DIV_W(DIV_W)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_i   (clk_div_i),
    .go_i    (eng_go),
    .op_i    (eng_op),
    .tx_i    (eng_tx),
    .sda_i   (sda_i),
    .done_o  (eng_done),
    .rx_o    (eng_rx),
    .ack_o   (eng_ack),
    .scl_oe_o(scl_oe_o),
    .sda_oe_o(sda_oe_o)
  );
endmodule

// File: rtl/spd_cmd_ctrl_chk.sv
module spd_cmd_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_we_i,
  input logic       cmd_rd_i,
  input logic       busy_o,
  input logic       rd_valid_o,
  input logic       wr_done_o,
  input logic       bus_err_o,
  input logic [7:0] rd_data_o,
  input logic       scl_oe_o,
  input logic       sda_oe_o
);
  a_r1_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && cmd_we_i |=> busy_o);
  a_r5_rd_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && cmd_we_i && cmd_rd_i |=> !rd_valid_o);
  a_r6_wr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && cmd_we_i && !cmd_rd_i |=> !wr_done_o);
  a_r8_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && cmd_we_i |=> !bus_err_o);
  a_r7_wr_not_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_done_o) |-> !bus_err_o);
  a_r7_rd_not_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> !bus_err_o);
  a_r4_data_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_data_o) |-> $rose(rd_valid_o));
  a_r3_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_done_o) |-> $fell(busy_o));
  a_r12_idle_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !scl_oe_o && !sda_oe_o);
endmodule

bind spd_cmd_ctrl spd_cmd_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_we_i  (cmd_we_i),
  .cmd_rd_i  (cmd_rd_i),
  .busy_o    (busy_o),
  .rd_valid_o(rd_valid_o),
  .wr_done_o (wr_done_o),
  .bus_err_o (bus_err_o),
  .rd_data_o (rd_data_o),
  .scl_oe_o  (scl_oe_o),
  .sda_oe_o  (sda_oe_o)
);

// File: tb/spd_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module spd_cmd_ctrl_tb_top;
  localparam logic [2:0] SL_SEL = 3'b010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] clk_div = 8'd3;
  logic cmd_we = 0, cmd_rd = 0;
  logic [3:0] cmd_dtype = 0;
  logic [2:0] cmd_sel = 0;
  logic [7:0] cmd_off = 0, cmd_wdata = 0;
  logic busy, rd_valid, wr_done, bus_err, scl_oe, sda_oe;
  logic [7:0] rd_data;
  logic sl_drv, scl_line, sda_line;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | sl_drv);

  spd_cmd_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clk_div_i(clk_div),
    .cmd_we_i(cmd_we), .cmd_rd_i(cmd_rd), .cmd_dev_type_i(cmd_dtype),
    .cmd_dev_sel_i(cmd_sel), .cmd_offset_i(cmd_off), .cmd_wdata_i(cmd_wdata),
    .busy_o(busy), .rd_valid_o(rd_valid), .wr_done_o(wr_done), .bus_err_o(bus_err),
    .rd_data_o(rd_data), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_line)
  );

  // ---------------- EEPROM slave model ----------------
  logic [7:0] mem [256];
  logic [7:0] sh, tx, ptr;
  logic [15:0] addr_hist;
  logic scl_q, sda_q, silent, xmit, rd_mode, addressed;
  int bcnt, phase, n_start, n_stop;
  bit nack_data = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      sh <= 0; tx <= 0; ptr <= 0; addr_hist <= 0;
      scl_q <= 1; sda_q <= 1; silent <= 1; xmit <= 0; rd_mode <= 0; addressed <= 0;
      bcnt <= 0; phase <= 0; n_start <= 0; n_stop <= 0; sl_drv <= 0;
    end else begin
      scl_q <= scl_line; sda_q <= sda_line;
      if (scl_line && scl_q && sda_q && !sda_line) begin
        n_start <= n_start + 1; bcnt <= 0; phase <= 0; xmit <= 0; silent <= 0; sl_drv <= 0;
      end else if (scl_line && scl_q && !sda_q && sda_line) begin
        n_stop <= n_stop + 1; silent <= 1; sl_drv <= 0;
      end else if (!silent) begin
        if (scl_line && !scl_q) begin
          if (bcnt < 8) begin
            if (!xmit) sh <= {sh[6:0], sda_line};
            bcnt <= bcnt + 1;
          end
        end else if (!scl_line && scl_q) begin
          if (!xmit) begin
            if (bcnt == 8) begin
              bcnt <= 9;
              if (phase == 0) begin
                addr_hist <= {addr_hist[7:0], sh};
                phase <= 1;
                if (sh[7:1] == {4'b1010, SL_SEL}) begin
                  addressed <= 1; rd_mode <= sh[0]; tx <= mem[ptr]; sl_drv <= 1;
                end else begin
                  addressed <= 0; sl_drv <= 0;
                end
              end else if (!addressed) sl_drv <= 0;
              else if (phase == 1) begin ptr <= sh; phase <= 2; sl_drv <= 1; end
              else begin
                if (!nack_data) mem[ptr] <= sh;
                sl_drv <= !nack_data;
              end
            end else if (bcnt == 9) begin
              bcnt <= 0; sl_drv <= 0;
              if (rd_mode && addressed) begin xmit <= 1; sl_drv <= ~tx[7]; end
            end
          end else begin
            if (bcnt < 8)       sl_drv <= ~tx[7-bcnt];
            else if (bcnt == 8) begin sl_drv <= 0; bcnt <= 9; end
            else                silent <= 1;
          end
        end
      end
    end
  end

  // SCL high-pulse monitor for R11
  int hi_cnt = 0, hi_min = 0, hi_max = 0;
  bit hi_valid = 0;
  logic scl_m = 1;
  always @(posedge clk) begin
    scl_m <= scl_line;
    if (!busy) hi_valid <= 0;
    else if (scl_line && !scl_m) begin hi_cnt <= 1; hi_valid <= 1; end
    else if (scl_line) hi_cnt <= hi_cnt + 1;
    else if (scl_m && hi_valid) begin
      hi_valid <= 0;
      if (hi_min == 0 || hi_cnt < hi_min) hi_min <= hi_cnt;
      if (hi_cnt > hi_max) hi_max <= hi_cnt;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input bit rd, input logic [3:0] dt, input logic [2:0] sel,
                       input logic [7:0] off, input logic [7:0] wd);
    @(negedge clk);
    cmd_we = 1; cmd_rd = rd; cmd_dtype = dt; cmd_sel = sel; cmd_off = off; cmd_wdata = wd;
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    if (busy) check(0, "R1", "watchdog busy timeout", 1, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(busy == 0 && rd_valid == 0 && wr_done == 0 && bus_err == 0, "R10", "flags",
          {busy, rd_valid, wr_done, bus_err}, 0);
    check(rd_data == 8'h00, "R10", "rd_data", rd_data, 0);
    check(!scl_oe && !sda_oe, "R12", "lines released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_write();
    int s0 = n_start, p0 = n_stop;
    issue(0, 4'b1010, SL_SEL, 8'h21, 8'hC3);
    check(busy == 1, "R1", "busy after strobe", busy, 1);
    wait_idle();
    check(wr_done == 1 && bus_err == 0, "R6", "wr_done after write", {wr_done, bus_err}, 2);
    check(mem[8'h21] == 8'hC3, "R3", "byte written", mem[8'h21], 8'hC3);
    check(addr_hist[7:0] == 8'hA4, "R2", "write address byte", addr_hist[7:0], 8'hA4);
    check(n_start - s0 == 1 && n_stop - p0 == 1, "R1", "one start/stop", n_start - s0, 1);
    check(!scl_oe && !sda_oe, "R12", "released after write", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_read(input logic [7:0] off, input logic [7:0] exp);
    int s0 = n_start;
    issue(1, 4'b1010, SL_SEL, off, 8'h00);
    check(rd_valid == 0, "R5", "rd_valid cleared on read accept", rd_valid, 0);
    wait_idle();
    check(rd_valid == 1 && bus_err == 0, "R4", "rd_valid", {rd_valid, bus_err}, 2);
    check(rd_data == exp, "R4", "read byte", rd_data, exp);
    check(addr_hist == 16'hA4A5, "R2", "read address bytes", addr_hist, 16'hA4A5);
    check(n_start - s0 == 2, "R1", "two starts on read", n_start - s0, 2);
  endtask

  task automatic t_flags_independent();
    bit wd = wr_done;
    issue(1, 4'b1010, SL_SEL, 8'h40, 8'h00);
    wait_idle();
    check(wr_done == wd, "R6", "read leaves wr_done", wr_done, wd);
    issue(0, 4'b1010, SL_SEL, 8'h41, 8'h11);
    wait_idle();
    check(rd_valid == 1, "R5", "write leaves rd_valid", rd_valid, 1);
  endtask

  task automatic t_busy_ignore();
    int s0 = n_start;
    issue(0, 4'b1010, SL_SEL, 8'h50, 8'hAB);
    repeat (20) @(negedge clk);
    issue(0, 4'b1010, SL_SEL, 8'h51, 8'hCD);
    wait_idle();
    check(n_start - s0 == 1, "R9", "strobe while busy starts nothing", n_start - s0, 1);
    check(mem[8'h51] == (8'h51 ^ 8'h5A), "R9", "ignored write", mem[8'h51], 8'h51 ^ 8'h5A);
    check(mem[8'h50] == 8'hAB, "R3", "first write landed", mem[8'h50], 8'hAB);
  endtask

  task automatic t_nack_wp();
    int p0 = n_stop;
    logic [7:0] keep = rd_data;
    issue(0, 4'b0110, SL_SEL, 8'h00, 8'h00);
    wait_idle();
    check(addr_hist[7:0] == 8'h64, "R2", "write-protect type on bus", addr_hist[7:0], 8'h64);
    check(bus_err == 1 && wr_done == 0, "R7", "address nack", {bus_err, wr_done}, 2);
    check(n_stop - p0 == 1, "R7", "stop after nack", n_stop - p0, 1);
    check(rd_data == keep, "R7", "rd_data kept", rd_data, keep);
  endtask

  task automatic t_nack_read();
    logic [7:0] keep = rd_data;
    issue(1, 4'b1010, 3'b101, 8'h10, 8'h00);
    check(bus_err == 0, "R8", "err cleared on accept", bus_err, 0);
    wait_idle();
    check(bus_err == 1 && rd_valid == 0, "R7", "read nack", {bus_err, rd_valid}, 2);
    check(rd_data == keep, "R7", "rd_data kept on read nack", rd_data, keep);
  endtask

  task automatic t_nack_data();
    nack_data = 1;
    issue(0, 4'b1010, SL_SEL, 8'h60, 8'h99);
    wait_idle();
    nack_data = 0;
    check(bus_err == 1 && wr_done == 0, "R7", "data nack", {bus_err, wr_done}, 2);
    check(mem[8'h60] == (8'h60 ^ 8'h5A), "R7", "no write on nack", mem[8'h60], 8'h60 ^ 8'h5A);
    issue(1, 4'b1010, SL_SEL, 8'h10, 8'h00);
    wait_idle();
    check(bus_err == 0 && rd_valid == 1, "R8", "good read after error", {bus_err, rd_valid}, 1);
  endtask

  task automatic t_divider(input logic [7:0] d);
    clk_div = d;
    @(negedge clk);
    hi_min = 0; hi_max = 0;
    issue(1, 4'b1010, SL_SEL, 8'h21, 8'h00);
    wait_idle();
    check(hi_min == 2 * (d + 1) && hi_max == 2 * (d + 1), "R11", "scl high cycles",
          hi_max, 2 * (d + 1));
    check(rd_data == 8'hC3, "R4", "read at divider", rd_data, 8'hC3);
  endtask

  task automatic t_same_cycle();
    int s0 = n_start;
    issue(0, 4'b1010, SL_SEL, 8'h70, 8'h12);
    cmd_we = 1; cmd_off = 8'h30; cmd_wdata = 8'h77;
    wait_idle();
    check(wr_done == 1, "R6", "done visible in idle cycle", wr_done, 1);
    @(negedge clk);
    check(busy == 1 && wr_done == 0, "R6", "held strobe taken, done cleared",
          {busy, wr_done}, 2);
    cmd_we = 0;
    wait_idle();
    check(mem[8'h70] == 8'h12 && mem[8'h30] == 8'h77, "R3", "both writes",
          {mem[8'h70], mem[8'h30]}, 16'h1277);
    check(n_start - s0 == 2, "R9", "one transaction per accepted strobe", n_start - s0, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write();
    t_read(8'h21, 8'hC3);
    t_read(8'h10, 8'h10 ^ 8'h5A);
    t_flags_independent();
    t_busy_ignore();
    t_nack_wp();
    t_nack_read();
    t_nack_data();
    t_divider(8'd0);
    t_divider(8'd4);
    clk_div = 8'd3;
    t_same_cycle();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL R1 watchdog expired: actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule